// File: doc/BRIEF.md
# Answer-Mode FSK Handshake Transmitter

This block takes a 300 bit/s answer-mode modem from the moment the line is taken off-hook to the point where user data flows. It first stays silent for the rest of the pre-answer quiet time. It then sends a 2100 Hz answer tone, holds a short pause, and sends continuous mark tone on the upper FSK channel. Meanwhile it waits for the demodulator to report enough valid periods of the caller's mark tone. After a further fixed hold of mark it switches to data mode. In data mode the level of the UART transmit line keys the transmit tone. The output is a square wave: a counter at the system clock toggles it once per half period.

Durations are counted in ticks of a 1/300 s strobe. They are given as millisecond parameters and rounded up to whole ticks. Once the caller has been detected, the block watches the demodulator's zero-crossing strobe. If no zero crossing arrives within a time-out, the call has ended: the block stops transmitting and returns to command mode, ready for the next ring.

Top module: `v21_answer_tx`

## Requirements
- R1: During and after a synchronous reset, `mode` is 0 (command) and `fsk_out` is low.
- R2: `mode` encodes 0 = command, 1 = ring detection, 2 = answering handshake and 3 = data. A `ring_edge` pulse in command mode moves `mode` to 1. In ring detection the block waits for `off_hook` and `fsk_out` stays low.
- R3: `off_hook` in ring detection moves `mode` to 2. `fsk_out` then stays low for PRE_MS (default 150 ms = 45 ticks).
- R4: The answer tone follows. It is a square wave at 2100 Hz with a half period of round(CLK_HZ/(2·f)) clocks (244 at 1.024 MHz), and it lasts ANS_MS (default 3300 ms = 990 ticks).
- R5: A silence of GAP_MS (default 75 ms = 23 ticks) follows. After it the block sends continuous 1650 Hz mark (half period 310), whatever the level of `tx_line`.
- R6: The block leaves the mark-detect phase only after DET_PERIODS (default 152) `period_ok` pulses. Only pulses that arrive during that phase count. Pulses received earlier are discarded.
- R7: After detection the block keeps sending mark for HOLD_MS (default 600 ms = 180 ticks) and then sets `mode` to 3.
- R8: In data mode a high `tx_line` selects 1650 Hz (half period 310) and a low one selects 1850 Hz (half period 277). On each change of `tx_line` the level is held and a full half period of the new tone starts. The next toggle therefore comes exactly one new half period after the change is sampled.
- R9: From the end of detection onward, if LOSS_MS (default 100 ms = 30 ticks) pass with no `zc_pulse`, the block returns to `mode` 0 with `fsk_out` low. Each `zc_pulse` restarts the timer and takes priority over an expiry in the same cycle.
- R10: `fsk_out` never rises before it has been low for at least the shortest half period (244 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ, default 1.024 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at TICK_HZ (1/300 s) |
| ring_edge | input | 1 | Pulse at the first ring transition |
| off_hook | input | 1 | High once the call has been qualified and the line is taken |
| tx_line | input | 1 | UART transmit bit stream (idle high) |
| zc_pulse | input | 1 | One-cycle strobe per received zero crossing |
| period_ok | input | 1 | One-cycle strobe per received period inside the caller mark window |
| fsk_out | output | 1 | Square-wave transmit signal |
| mode | output | 2 | Operating mode, encoded as in R2 |

## Verification
The assertions assume that `tick`, `zc_pulse` and `period_ok` are single-cycle strobes. They also assume that `tick` is far enough apart that a tone of several half periods fits between two ticks. The bench drives all three from registered generators or short tasks: ticks every 1000 clocks and zero crossings every 400. It changes `ring_edge`, `off_hook` and `tx_line` only on falling clock edges. The millisecond parameters are scaled down to a few ticks so the whole call fits in the run. The clock rate and tone frequencies keep their defaults, so the half periods are the real ones.

// File: rtl/v21_pkg.sv
package v21_pkg;

  typedef enum logic [1:0] {
    MODE_CMD       = 2'd0,
    MODE_RING      = 2'd1,
    MODE_HANDSHAKE = 2'd2,
    MODE_DATA      = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RING,
    ST_PRE,
    ST_ANSWER,
    ST_GAP,
    ST_DETECT,
    ST_HOLD,
    ST_DATA
  } seq_state_e;

  typedef enum logic [1:0] {
    TONE_OFF,
    TONE_MARK,
    TONE_SPACE,
    TONE_ANSWER
  } tone_e;

  function automatic int ms_to_ticks(input int ms, input int tick_hz);
    return (ms * tick_hz + 999) / 1000;
  endfunction

  function automatic int half_clocks(input int clk_hz, input int freq_hz);
    return (clk_hz + freq_hz) / (2 * freq_hz);
  endfunction

  function automatic mode_e mode_of(input seq_state_e s);
    case (s)
      ST_IDLE:           return MODE_CMD;
      ST_RING:           return MODE_RING;
      ST_DATA:           return MODE_DATA;
      default:           return MODE_HANDSHAKE;
    endcase
  endfunction

endpackage

// File: rtl/v21_tone_gen.sv
module v21_tone_gen
  import v21_pkg::*;
#(
  parameter int CLK_HZ   = 1024000,
  parameter int MARK_HZ  = 1650,
  parameter int SPACE_HZ = 1850,
  parameter int ANS_HZ   = 2100
) (
  input  logic  clk,
  input  logic  rst,
  input  tone_e tone,
  output logic  wave
);

  localparam int HALF_MARK  = half_clocks(CLK_HZ, MARK_HZ);
  localparam int HALF_SPACE = half_clocks(CLK_HZ, SPACE_HZ);
  localparam int HALF_ANS   = half_clocks(CLK_HZ, ANS_HZ);
  localparam int HALF_MAX   = (HALF_MARK > HALF_SPACE)
                              ? ((HALF_MARK > HALF_ANS) ? HALF_MARK : HALF_ANS)
                              : ((HALF_SPACE > HALF_ANS) ? HALF_SPACE : HALF_ANS);
  localparam int CW         = $clog2(HALF_MAX + 1);

  tone_e          sel_q;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  half_cur;

  always_comb begin
    case (sel_q)
      TONE_MARK:   half_cur = CW'(HALF_MARK);
      TONE_SPACE:  half_cur = CW'(HALF_SPACE);
      TONE_ANSWER: half_cur = CW'(HALF_ANS);
      default:     half_cur = CW'(HALF_MAX);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= TONE_OFF;
      cnt   <= '0;
      wave  <= 1'b0;
    end else begin
      sel_q <= tone;
      if (tone == TONE_OFF) begin
        cnt  <= '0;
        wave <= 1'b0;
      end else if (tone != sel_q) begin
        cnt  <= '0;
      end else if (cnt == half_cur - 1'b1) begin
        cnt  <= '0;
        wave <= ~wave;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/v21_carrier_mon.sv
module v21_carrier_mon #(
  parameter int DET_PERIODS = 152,
  parameter int LOSS_TICKS  = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic det_en,
  input  logic loss_en,
  input  logic period_ok,
  input  logic zc_pulse,
  output logic det_done,
  output logic carrier_lost
);

  localparam int DCW = $clog2(DET_PERIODS + 1);
  localparam int LCW = $clog2(LOSS_TICKS + 1);

  logic [DCW-1:0] det_cnt;
  logic [LCW-1:0] loss_cnt;
  logic           det_full;
  logic           loss_full;

  assign det_full  = (det_cnt == DCW'(DET_PERIODS));
  assign loss_full = (loss_cnt == LCW'(LOSS_TICKS));

  always_ff @(posedge clk) begin
    if (rst || !det_en) begin
      det_cnt <= '0;
    end else if (period_ok && !det_full) begin
      det_cnt <= det_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !loss_en || zc_pulse) begin
      loss_cnt <= '0;
    end else if (tick && !loss_full) begin
      loss_cnt <= loss_cnt + 1'b1;
    end
  end

  assign det_done     = det_full;
  assign carrier_lost = loss_full && !zc_pulse;

endmodule

// File: rtl/v21_seq.sv
module v21_seq
  import v21_pkg::*;
#(
  parameter int PRE_T  = 45,
  parameter int ANS_T  = 990,
  parameter int GAP_T  = 23,
  parameter int HOLD_T = 180
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  ring_edge,
  input  logic  off_hook,
  input  logic  tx_line,
  input  logic  det_done,
  input  logic  carrier_lost,
  output tone_e tone,
  output logic  det_en,
  output logic  loss_en,
  output mode_e mode
);

  localparam int MAX_AB = (PRE_T > ANS_T) ? PRE_T : ANS_T;
  localparam int MAX_CD = (GAP_T > HOLD_T) ? GAP_T : HOLD_T;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int DW     = $clog2(MAX_T + 1);

  seq_state_e     st, st_d;
  logic [DW-1:0]  dur;
  logic [DW-1:0]  lim;
  logic           timed;
  logic           dur_done;

  always_comb begin
    timed = 1'b1;
    case (st)
      ST_PRE:    lim = DW'(PRE_T);
      ST_ANSWER: lim = DW'(ANS_T);
      ST_GAP:    lim = DW'(GAP_T);
      ST_HOLD:   lim = DW'(HOLD_T);
      default: begin
        lim   = DW'(1);
        timed = 1'b0;
      end
    endcase
  end

  assign dur_done = tick && timed && (dur == lim - 1'b1);

  always_comb begin
    st_d = st;
    case (st)
      ST_IDLE:   if (ring_edge) st_d = ST_RING;
      ST_RING:   if (off_hook)  st_d = ST_PRE;
      ST_PRE:    if (dur_done)  st_d = ST_ANSWER;
      ST_ANSWER: if (dur_done)  st_d = ST_GAP;
      ST_GAP:    if (dur_done)  st_d = ST_DETECT;
      ST_DETECT: if (det_done)  st_d = ST_HOLD;
      ST_HOLD: begin
        if (carrier_lost)       st_d = ST_IDLE;
        else if (dur_done)      st_d = ST_DATA;
      end
      ST_DATA:   if (carrier_lost) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      dur  <= '0;
      mode <= MODE_CMD;
    end else begin
      st   <= st_d;
      mode <= mode_of(st_d);
      if (st_d != st) begin
        dur <= '0;
      end else if (tick && timed) begin
        dur <= dur + 1'b1;
      end
    end
  end

  always_comb begin
    case (st)
      ST_ANSWER:                  tone = TONE_ANSWER;
      ST_DETECT, ST_HOLD:         tone = TONE_MARK;
      ST_DATA:                    tone = tx_line ? TONE_MARK : TONE_SPACE;
      default:                    tone = TONE_OFF;
    endcase
  end

  assign det_en  = (st == ST_DETECT);
  assign loss_en = (st == ST_HOLD) || (st == ST_DATA);

endmodule

// File: rtl/v21_answer_tx.sv
module v21_answer_tx
  import v21_pkg::*;
#(
  parameter int CLK_HZ      = 1024000,
  parameter int TICK_HZ     = 300,
  parameter int MARK_HZ     = 1650,
  parameter int SPACE_HZ    = 1850,
  parameter int ANS_HZ      = 2100,
  parameter int PRE_MS      = 150,
  parameter int ANS_MS      = 3300,
  parameter int GAP_MS      = 75,
  parameter int HOLD_MS     = 600,
  parameter int LOSS_MS     = 100,
  parameter int DET_PERIODS = 152
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ring_edge,
  input  logic       off_hook,
  input  logic       tx_line,
  input  logic       zc_pulse,
  input  logic       period_ok,
  output logic       fsk_out,
  output logic [1:0] mode
);

  localparam int PRE_T  = ms_to_ticks(PRE_MS, TICK_HZ);
  localparam int ANS_T  = ms_to_ticks(ANS_MS, TICK_HZ);
  localparam int GAP_T  = ms_to_ticks(GAP_MS, TICK_HZ);
  localparam int HOLD_T = ms_to_ticks(HOLD_MS, TICK_HZ);
  localparam int LOSS_T = ms_to_ticks(LOSS_MS, TICK_HZ);

  tone_e tone;
  mode_e mode_q;
  logic  det_en, loss_en, det_done, carrier_lost;

  v21_seq #(
    .PRE_T (PRE_T),
    .ANS_T (ANS_T),
    .GAP_T (GAP_T),
    .HOLD_T(HOLD_T)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .ring_edge   (ring_edge),
    .off_hook    (off_hook),
    .tx_line     (tx_line),
    .det_done    (det_done),
    .carrier_lost(carrier_lost),
    .tone        (tone),
    .det_en      (det_en),
    .loss_en     (loss_en),
    .mode        (mode_q)
  );

  v21_carrier_mon #(
    .DET_PERIODS(DET_PERIODS),
    .LOSS_TICKS (LOSS_T)
  ) u_mon (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .det_en      (det_en),
    .loss_en     (loss_en),
    .period_ok   (period_ok),
    .zc_pulse    (zc_pulse),
    .det_done    (det_done),
    .carrier_lost(carrier_lost)
  );

  v21_tone_gen #(
    .CLK_HZ  (CLK_HZ),
    .MARK_HZ (MARK_HZ),
    .SPACE_HZ(SPACE_HZ),
    .ANS_HZ  (ANS_HZ)
  ) u_tone (
    .clk (clk),
    .rst (rst),
    .tone(tone),
    .wave(fsk_out)
  );

  assign mode = mode_q;

endmodule

// File: rtl/v21_answer_tx_chk.sv
module v21_answer_tx_chk #(
  parameter int CLK_HZ = 1024000,
  parameter int ANS_HZ = 2100
) (
  input logic       clk,
  input logic       rst,
  input logic       ring_edge,
  input logic       off_hook,
  input logic       zc_pulse,
  input logic       fsk_out,
  input logic [1:0] mode
);

  localparam int MIN_HALF = (CLK_HZ + ANS_HZ) / (2 * ANS_HZ);
  localparam int RW       = $clog2(MIN_HALF + 2);

  logic          prev_out;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_out <= 1'b0;
      run      <= '0;
    end else begin
      prev_out <= fsk_out;
      if (fsk_out != prev_out) run <= '0;
      else if (run != RW'(MIN_HALF + 1)) run <= run + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (mode == 2'd0 && !fsk_out)); // R1

  AST_RING_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && ring_edge) |=> (mode == 2'd1)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode inside {2'd0, 2'd1} && $past(mode) inside {2'd0, 2'd1}) |-> !fsk_out); // R2

  AST_OFFHOOK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && off_hook) |=> (mode == 2'd2)); // R3

  AST_MODE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> (mode == $past(mode) + 2'd1 || mode == 2'd0)); // R7

  AST_ZC_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && zc_pulse) |=> (mode == 2'd3)); // R9

  AST_HALF_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (fsk_out && !prev_out) |-> (run >= RW'(MIN_HALF - 2))); // R10

endmodule

bind v21_answer_tx v21_answer_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ring_edge(ring_edge),
  .off_hook (off_hook),
  .zc_pulse (zc_pulse),
  .fsk_out  (fsk_out),
  .mode     (mode)
);

// File: tb/sim_v21_answer_tx.sv
module sim_v21_answer_tx;

  localparam int TD      = 1000;
  localparam int ZC_GAP  = 400;
  localparam int PRE_T   = 3;
  localparam int ANS_T   = 6;
  localparam int GAP_T   = 3;
  localparam int HOLD_T  = 6;
  localparam int LOSS_T  = 6;
  localparam int DETN    = 8;
  localparam int H_ANS   = 244;
  localparam int H_MARK  = 310;
  localparam int H_SPACE = 277;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, ring_edge = 1'b0, off_hook = 1'b0;
  logic tx_line = 1'b1, zc_pulse = 1'b0, period_ok = 1'b0, carrier_on = 1'b0;
  logic       fsk_out;
  logic [1:0] mode;
  int n_chk = 0, n_fail = 0;
  int tdiv = 0, zdiv = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      tdiv <= 0; tick <= 1'b0; zdiv <= 0; zc_pulse <= 1'b0;
    end else begin
      tdiv     <= (tdiv == TD - 1) ? 0 : tdiv + 1;
      tick     <= (tdiv == TD - 1);
      zdiv     <= (zdiv == ZC_GAP - 1) ? 0 : zdiv + 1;
      zc_pulse <= carrier_on && (zdiv == ZC_GAP - 1);
    end
  end

  v21_answer_tx #(
    .PRE_MS(10), .ANS_MS(20), .GAP_MS(10), .HOLD_MS(20), .LOSS_MS(20),
    .DET_PERIODS(DETN)
  ) u0 (
    .clk(clk), .rst(rst), .tick(tick), .ring_edge(ring_edge), .off_hook(off_hook),
    .tx_line(tx_line), .zc_pulse(zc_pulse), .period_ok(period_ok),
    .fsk_out(fsk_out), .mode(mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (tick) seen++;
    end
  endtask

  task automatic count_edges(input int n, output int e);
    logic p;
    e = 0;
    p = fsk_out;
    repeat (n) begin
      @(negedge clk);
      if (fsk_out !== p) begin e++; p = fsk_out; end
    end
  endtask

  task automatic wait_edge();
    logic p;
    int guard = 0;
    p = fsk_out;
    do begin @(negedge clk); guard++; end while (fsk_out === p && guard < 2000);
  endtask

  task automatic half_len(output int len);
    logic p;
    wait_edge();
    p = fsk_out;
    len = 0;
    do begin @(negedge clk); len++; end while (fsk_out === p && len < 2000);
  endtask

  task automatic pulse_periods(input int n);
    repeat (n) begin
      @(negedge clk) period_ok = 1'b1;
      @(negedge clk) period_ok = 1'b0;
      cyc(3);
    end
  endtask

  task automatic t_reset();
    chk(mode == 2'd0, "R1 mode during reset", mode, 0);
    @(negedge clk) rst = 1'b0;
    cyc(3);
    chk(mode == 2'd0, "R1 mode after reset", mode, 0);
    chk(fsk_out == 1'b0, "R1 output after reset", fsk_out, 0);
  endtask

  task automatic t_ring();
    int e;
    @(negedge clk) ring_edge = 1'b1;
    @(negedge clk) ring_edge = 1'b0;
    cyc(2);
    chk(mode == 2'd1, "R2 ring entry", mode, 1);
    wait_ticks(3);
    count_edges(500, e);
    chk(e == 0 && mode == 2'd1, "R2 waits silent for off-hook", e, 0);
  endtask

  task automatic t_answer();
    int e, h;
    @(negedge clk) off_hook = 1'b1;
    wait_ticks(PRE_T - 1);
    cyc(4);
    chk(mode == 2'd2, "R3 handshake mode", mode, 2);
    count_edges(800, e);
    chk(e == 0, "R3 pre-answer silence", e, 0);
    wait_ticks(1);
    half_len(h);
    chk(h == H_ANS, "R4 answer half period", h, H_ANS);
    wait_ticks(ANS_T - 1);
    cyc(4);
    count_edges(800, e);
    chk(e > 0, "R4 answer tone still on in last tick", e, 1);
    wait_ticks(1);
    cyc(4);
    pulse_periods(5);
    count_edges(800, e);
    chk(e == 0, "R5 gap silence start", e, 0);
    wait_ticks(GAP_T - 1);
    cyc(4);
    count_edges(800, e);
    chk(e == 0, "R5 gap silence end", e, 0);
    tx_line = 1'b0;
    wait_ticks(1);
    half_len(h);
    chk(h == H_MARK, "R5 mark tone with tx low", h, H_MARK);
  endtask

  task automatic t_detect();
    int h;
    carrier_on = 1'b1;
    pulse_periods(DETN - 1);
    wait_ticks(2);
    cyc(4);
    chk(mode == 2'd2, "R6 short count keeps waiting", mode, 2);
    half_len(h);
    chk(h == H_MARK, "R6 mark while waiting", h, H_MARK);
    tx_line = 1'b1;
    @(negedge clk) period_ok = 1'b1;
    @(negedge clk) period_ok = 1'b0;
    wait_ticks(HOLD_T - 1);
    cyc(4);
    chk(mode == 2'd2, "R7 hold still handshake", mode, 2);
    wait_ticks(1);
    cyc(4);
    chk(mode == 2'd3, "R7 data mode after hold", mode, 3);
  endtask

  task automatic t_data();
    int h, d;
    half_len(h);
    chk(h == H_MARK, "R8 tx high gives mark", h, H_MARK);
    @(negedge clk) tx_line = 1'b0;
    half_len(h);
    chk(h == H_SPACE, "R8 tx low gives space", h, H_SPACE);
    cyc(5);
    @(negedge clk) tx_line = 1'b1;
    d = 0;
    begin
      logic p;
      p = fsk_out;
      do begin @(negedge clk); d++; end while (fsk_out === p && d < 2000);
    end
    chk(d == H_MARK + 1, "R8 restart on tx change", d, H_MARK + 1);
  endtask

  task automatic t_loss();
    int e;
    do @(negedge clk); while (!zc_pulse);
    carrier_on = 1'b0;
    wait_ticks(LOSS_T - 1);
    cyc(4);
    chk(mode == 2'd3, "R9 data kept before time-out", mode, 3);
    wait_ticks(1);
    cyc(4);
    chk(mode == 2'd0, "R9 command after time-out", mode, 0);
    count_edges(600, e);
    chk(e == 0 && fsk_out == 1'b0, "R9 output stopped", e, 0);
    off_hook = 1'b0;
    @(negedge clk) ring_edge = 1'b1;
    @(negedge clk) ring_edge = 1'b0;
    cyc(2);
    chk(mode == 2'd1, "R2 ring re-entry after loss", mode, 1);
  endtask

  initial begin
    cyc(5);
    t_reset();
    t_ring();
    t_answer();
    t_detect();
    t_data();
    t_loss();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule